// File: doc/BRIEF.md
# SPI Frame CRC Engine

This block sits beside the shift register of a serial peripheral port. It computes two bit-serial CRCs over the traffic. One covers the bits sent out and one covers the bits taken in. Both use a polynomial that software programs. The shift logic gives the engine one strobe for each sampled bit, together with the outgoing data bit and the incoming line bit. The engine counts frame bits itself, using either 8 or 16 bits per frame.

Software raises a one-cycle request once it has queued the final data frame. The engine then waits until the data frame in flight has finished. If one more frame is still queued, it waits for that frame too. It then drives its transmit CRC onto the outgoing line as one extra frame, most significant bit first. While that frame is on the wire, both CRC registers hold their values. Each received bit of the frame is compared against the receive CRC. A mismatch raises a sticky error flag, and an interrupt request follows when the error interrupt is enabled.

Top module: `spi_crc_engine`

The sequencer has four states:
- `ST_OFF`: disabled.
- `ST_DATA`: accumulating data bits.
- `ST_ARMED`: a request has been taken and data frames are still completing.
- `ST_CRC`: the CRC frame is on the line.

The transitions are:
- OFF→DATA when enable is high. This transition also clears both registers.
- DATA→ARMED on a request.
- ARMED→CRC at the last bit of a frame when nothing is queued.
- ARMED→ARMED at the last bit of a frame when another frame is queued.
- CRC→DATA at the last CRC bit.
- Any state→OFF when enable is low.

## Requirements
- R1: After reset both CRC registers read zero, and the error flag, interrupt, pending request and CRC-phase outputs are all low.
- R2: Each cycle in which `cfg_crc_en` is first seen high clears both CRC registers to zero.
- R3: On every `sample_stb` in a data frame, each register takes one step. Let f = input bit XOR register top bit (bit 15 in 16-bit mode, bit 7 in 8-bit mode). The register shifts left by one, and when f is 1 the polynomial is XORed in.
- R4: When `cfg_wide`=0, frames and the CRC are 8 bits, only `cfg_poly[7:0]` is used, and bits 15:8 of both registers stay zero. When `cfg_wide`=1, frames and the CRC are 16 bits.
- R5: After a `crc_next_req` pulse, the frame that follows the current data frame is the CRC frame. During it `crc_phase` is high and `tx_line` carries the transmit CRC, most significant bit first.
- R6: If `tx_queued` is high at the last bit of a frame after the request was taken, the next frame is still a data frame, and the CRC frame follows it.
- R7: Neither CRC register changes while the CRC frame is being shifted.
- R8: `crc_next_pending` is high from the request until the CRC frame completes, then clears by itself. A request made while it is already high has no effect.
- R9: If any received bit of the CRC frame differs from the matching bit of the receive CRC, `crc_err` is set at the end of the frame. It stays set until an `err_clr` pulse.
- R10: `err_irq` is high exactly when `crc_err` is high and `cfg_err_ie` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_crc_en | input | 1 | CRC enable; a rising level clears both registers |
| cfg_wide | input | 1 | Frame size: 0 = 8 bits, 1 = 16 bits |
| cfg_poly | input | 16 | Generator polynomial |
| cfg_err_ie | input | 1 | Error interrupt enable |
| crc_next_req | input | 1 | Software pulse asking for the CRC frame |
| err_clr | input | 1 | Software pulse that clears the error flag |
| sample_stb | input | 1 | One pulse for each sampled bit |
| tx_data_bit | input | 1 | Data bit the shifter is sending |
| tx_queued | input | 1 | Another data frame waits in the transmit buffer |
| rx_bit | input | 1 | Bit sampled from the incoming line |
| tx_line | output | 1 | Outgoing bit: data, or CRC during the CRC frame |
| crc_phase | output | 1 | CRC frame in progress |
| crc_next_pending | output | 1 | Request taken and not yet served |
| tx_crc_q | output | 16 | Transmit CRC register |
| rx_crc_q | output | 16 | Receive CRC register |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench sweeps both frame sizes, three polynomials and three transfer shapes, with the incoming line looped back from the outgoing one.
- **Clean transfer.** A design that let the registers keep running during the CRC frame would change them and fail to match its own check, so a clean transfer would report an error.
- **One flipped CRC bit.** A design that compared only the last bit, or cleared the flag itself, would miss a single flipped bit at an early position, or lose the flag after it was set.
- **Request with a frame still queued.** A design that ignored `tx_queued` would put the CRC in place of the queued data frame.
- **Request during the CRC frame.** A design that accepted this second request would leave a request pending after the CRC frame.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DATA  = 2'd1,
        ST_ARMED = 2'd2,
        ST_CRC   = 2'd3
    } crc_state_e;
endpackage

// File: rtl/spi_crc_lfsr.sv
module spi_crc_lfsr #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         wide,
    input  logic [W-1:0] poly,
    input  logic         din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

    logic         top_bit;
    logic         fb;
    logic [W-1:0] poly_eff;
    logic [W-1:0] shifted;
    logic [W-1:0] nxt;

    always_comb begin
        top_bit  = wide ? q[W-1] : q[NW-1];
        fb       = din ^ top_bit;
        poly_eff = wide ? poly : (poly & NMASK);
        shifted  = {q[W-2:0], 1'b0};
        nxt      = fb ? (shifted ^ poly_eff) : shifted;
        if (!wide) begin
            nxt = nxt & NMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (adv) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/spi_crc_seq.sv
module spi_crc_seq
    import spi_crc_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wide,
    input  logic          stb,
    input  logic          next_req,
    input  logic          queued,
    output crc_state_e    state,
    output logic [IW-1:0] sel,
    output logic          clr,
    output logic          adv,
    output logic          chk,
    output logic          last,
    output logic          pending
);
    crc_state_e    state_d;
    logic [IW-1:0] cnt;
    logic [IW-1:0] lim;

    assign lim  = wide ? IW'(W - 1) : IW'(NW - 1);
    assign last = (cnt == lim);
    assign sel  = lim - cnt;

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:   if (en) state_d = ST_DATA;
            ST_DATA:  if (!en) state_d = ST_OFF;
                      else if (next_req) state_d = ST_ARMED;
            ST_ARMED: if (!en) state_d = ST_OFF;
                      else if (stb && last && !queued) state_d = ST_CRC;
            ST_CRC:   if (!en) state_d = ST_OFF;
                      else if (stb && last) state_d = ST_DATA;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_d;
        end
    end

    // frame bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_OFF) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        clr     = 1'b0;
        adv     = 1'b0;
        chk     = 1'b0;
        pending = 1'b0;
        unique case (state)
            ST_OFF:   clr = en;
            ST_DATA:  adv = stb;
            ST_ARMED: begin
                adv     = stb;
                pending = 1'b1;
            end
            ST_CRC:   begin
                chk     = stb;
                pending = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/spi_crc_errchk.sv
module spi_crc_errchk (
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    input  logic chk,
    input  logic last,
    input  logic rx_bit,
    input  logic exp_bit,
    input  logic err_clr,
    output logic err
);
    logic mism_q;
    logic bit_bad;
    logic set_err;

    assign bit_bad = rx_bit ^ exp_bit;
    assign set_err = chk && last && (mism_q || bit_bad);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else if (off || (chk && last)) begin
            mism_q <= 1'b0;
        end else if (chk) begin
            mism_q <= mism_q | bit_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (set_err) begin
            err <= 1'b1;
        end else if (err_clr) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_crc_engine.sv
module spi_crc_engine
    import spi_crc_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 8,
    localparam int IW = $clog2(W),
    localparam int NLANE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_crc_en,
    input  logic         cfg_wide,
    input  logic [W-1:0] cfg_poly,
    input  logic         cfg_err_ie,
    input  logic         crc_next_req,
    input  logic         err_clr,
    input  logic         sample_stb,
    input  logic         tx_data_bit,
    input  logic         tx_queued,
    input  logic         rx_bit,
    output logic         tx_line,
    output logic         crc_phase,
    output logic         crc_next_pending,
    output logic [W-1:0] tx_crc_q,
    output logic [W-1:0] rx_crc_q,
    output logic         crc_err,
    output logic         err_irq
);
    crc_state_e    state;
    logic [IW-1:0] sel;
    logic          clr, adv, chk, last;
    logic [NLANE-1:0] lane_din;
    logic [W-1:0]     lane_q [NLANE];

    spi_crc_seq #(.W(W), .NW(NW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_crc_en),
        .wide     (cfg_wide),
        .stb      (sample_stb),
        .next_req (crc_next_req),
        .queued   (tx_queued),
        .state    (state),
        .sel      (sel),
        .clr      (clr),
        .adv      (adv),
        .chk      (chk),
        .last     (last),
        .pending  (crc_next_pending)
    );

    assign lane_din = {rx_bit, tx_data_bit};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        spi_crc_lfsr #(.W(W), .NW(NW)) lfsr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .adv   (adv),
            .wide  (cfg_wide),
            .poly  (cfg_poly),
            .din   (lane_din[g]),
            .q     (lane_q[g])
        );
    end

    assign tx_crc_q  = lane_q[0];
    assign rx_crc_q  = lane_q[1];
    assign crc_phase = (state == ST_CRC);
    assign tx_line   = crc_phase ? tx_crc_q[sel] : tx_data_bit;

    spi_crc_errchk err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .off     (state == ST_OFF),
        .chk     (chk),
        .last    (last),
        .rx_bit  (rx_bit),
        .exp_bit (rx_crc_q[sel]),
        .err_clr (err_clr),
        .err     (crc_err)
    );

    assign err_irq = crc_err & cfg_err_ie;
endmodule

// File: rtl/spi_crc_engine_chk.sv
module spi_crc_engine_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_crc_en,
    input logic         err_clr,
    input logic         crc_phase,
    input logic         crc_next_pending,
    input logic [W-1:0] tx_crc_q,
    input logic [W-1:0] rx_crc_q,
    input logic         crc_err,
    input logic         err_irq
);
    a_r2_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_crc_en) |=> (tx_crc_q == '0 && rx_crc_q == '0));

    a_r7_frozen_in_crc: assert property (@(posedge clk) disable iff (!rst_n)
        crc_phase |=> ($stable(tx_crc_q) && $stable(rx_crc_q)));

    a_r8_pending_clears_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_next_pending) |-> ($past(crc_phase) || !$past(cfg_crc_en)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);

    a_r9_err_after_crc_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(crc_phase));

    a_r10_no_irq_without_err: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_err |-> !err_irq);
endmodule

bind spi_crc_engine spi_crc_engine_chk #(.W(W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_crc_en       (cfg_crc_en),
    .err_clr          (err_clr),
    .crc_phase        (crc_phase),
    .crc_next_pending (crc_next_pending),
    .tx_crc_q         (tx_crc_q),
    .rx_crc_q         (rx_crc_q),
    .crc_err          (crc_err),
    .err_irq          (err_irq)
);

// File: tb/spi_crc_engine_tb_top.sv
module spi_crc_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_crc_en = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [15:0] cfg_poly = 16'h0;
    logic        cfg_err_ie = 1'b0;
    logic        crc_next_req = 1'b0;
    logic        err_clr = 1'b0;
    logic        sample_stb = 1'b0;
    logic        tx_data_bit = 1'b0;
    logic        tx_queued = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx_line;
    logic        crc_phase;
    logic        crc_next_pending;
    logic [15:0] tx_crc_q;
    logic [15:0] rx_crc_q;
    logic        crc_err;
    logic        err_irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_crc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_crc_en(cfg_crc_en), .cfg_wide(cfg_wide),
        .cfg_poly(cfg_poly), .cfg_err_ie(cfg_err_ie), .crc_next_req(crc_next_req),
        .err_clr(err_clr), .sample_stb(sample_stb), .tx_data_bit(tx_data_bit),
        .tx_queued(tx_queued), .rx_bit(rx_bit), .tx_line(tx_line),
        .crc_phase(crc_phase), .crc_next_pending(crc_next_pending),
        .tx_crc_q(tx_crc_q), .rx_crc_q(rx_crc_q), .crc_err(crc_err), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic b,
                                           input int w, input logic [15:0] p);
        logic fb;
        logic [15:0] r;
        fb = b ^ ((w == 16) ? c[15] : c[7]);
        r  = {c[14:0], 1'b0};
        if (fb) r = r ^ ((w == 16) ? p : (p & 16'h00FF));
        if (w == 8) r = r & 16'h00FF;
        return r;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // one data frame, loopback, MSB first; optional request at bit req_bit
    task automatic send_frame(input logic [15:0] val, input int w, input int req_bit,
                              input logic pend, inout logic [15:0] model,
                              output logic phase_seen, output logic line_bad);
        phase_seen = 1'b0;
        line_bad   = 1'b0;
        tx_queued  = pend;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            tx_data_bit  = val[w-1-i];
            sample_stb   = 1'b1;
            crc_next_req = (i == req_bit);
            #1;
            if (crc_phase) phase_seen = 1'b1;
            if (tx_line !== val[w-1-i]) line_bad = 1'b1;
            rx_bit = tx_line;
            model  = m_step(model, val[w-1-i], w, cfg_poly);
            @(posedge clk); #1;
            sample_stb   = 1'b0;
            crc_next_req = 1'b0;
        end
        tx_queued = 1'b0;
    endtask

    // CRC frame: capture the line, flip received bit flip_at (if in range)
    task automatic send_crc(input int w, input int flip_at, input logic req_again,
                            output logic [15:0] word, output logic phase_all);
        word = '0;
        phase_all = 1'b1;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            tx_data_bit  = 1'b0;
            sample_stb   = 1'b1;
            crc_next_req = req_again && (i == 0);
            #1;
            if (!crc_phase) phase_all = 1'b0;
            word   = {word[14:0], tx_line};
            rx_bit = tx_line ^ (i == flip_at);
            @(posedge clk); #1;
            sample_stb   = 1'b0;
            crc_next_req = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] polys [3];
        polys[0] = 16'h1021;
        polys[1] = 16'h8005;
        polys[2] = 16'h0007;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check("R1 tx_crc", tx_crc_q, 16'h0);
        check("R1 rx_crc", rx_crc_q, 16'h0);
        check("R1 flags", {12'h0, crc_err, err_irq, crc_next_pending, crc_phase}, 16'h0);
        rst_n = 1'b1;
        tick();

        for (int wi = 0; wi < 2; wi++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int v = 0; v < 3; v++) begin
                    int w;
                    logic [15:0] model;
                    logic [15:0] word;
                    logic ph, lb, pall;
                    w          = wi ? 16 : 8;
                    cfg_wide   = wi[0];
                    cfg_poly   = polys[pi];
                    cfg_err_ie = pi[0];
                    cfg_crc_en = 1'b0;
                    tick();
                    tick();
                    cfg_crc_en = 1'b1;
                    tick();
                    // R2: enable clears both registers
                    check("R2 tx_crc cleared", tx_crc_q, 16'h0);
                    check("R2 rx_crc cleared", rx_crc_q, 16'h0);
                    model = '0;
                    for (int f = 0; f < 3; f++) begin
                        int rb;
                        logic pd;
                        lcg = next_rand(lcg);
                        rb  = -1;
                        pd  = 1'b0;
                        if (v == 2 && f == 1) begin rb = 1; pd = 1'b1; end
                        if (v != 2 && f == 2) rb = 1;
                        send_frame(lcg[23:8] & ((w == 16) ? 16'hFFFF : 16'h00FF),
                                   w, rb, pd, model, ph, lb);
                        if (v == 2 && f == 2) begin
                            // R6: queued frame is still data
                            check("R6 queued frame is data phase", {15'h0, ph}, 16'h0);
                            check("R6 queued frame line", {15'h0, lb}, 16'h0);
                        end
                    end
                    // R3 / R4: register steps and width
                    check("R3 tx_crc after data", tx_crc_q, model);
                    check("R3 rx_crc after data", rx_crc_q, model);
                    if (w == 8) check("R4 upper bits zero", {8'h0, tx_crc_q[15:8]}, 16'h0);
                    check("R8 pending before crc", {15'h0, crc_next_pending}, 16'h1);
                    lcg = next_rand(lcg);
                    send_crc(w, (v == 1) ? int'(lcg[11:8]) % w : -1, v == 0, word, pall);
                    // R5: CRC frame content and phase
                    check("R5 crc on line", word, model);
                    check("R5 crc phase", {15'h0, pall}, 16'h1);
                    // R7: registers frozen through CRC frame
                    check("R7 tx_crc frozen", tx_crc_q, model);
                    check("R7 rx_crc frozen", rx_crc_q, model);
                    // R8: auto clear, repeat request ignored
                    check("R8 pending cleared", {15'h0, crc_next_pending}, 16'h0);
                    check("R5 back to data", {15'h0, crc_phase}, 16'h0);
                    // R9 / R10
                    check("R9 err flag", {15'h0, crc_err}, {15'h0, v == 1});
                    check("R10 irq", {15'h0, err_irq}, {15'h0, (v == 1) && pi[0]});
                    if (v == 1) begin
                        repeat (4) tick();
                        check("R9 err sticky", {15'h0, crc_err}, 16'h1);
                        err_clr = 1'b1;
                        tick();
                        err_clr = 1'b0;
                        check("R9 err cleared by write", {15'h0, crc_err}, 16'h0);
                        check("R10 irq drops", {15'h0, err_irq}, 16'h0);
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule